// File: doc/BRIEF.md
# Associative Message Acceptance Filter

This block decides which received CAN frames a node keeps. A host programs a small table of message objects, each holding an 11-bit identifier, a remote-request flag, an enable bit and an interrupt-enable bit. Each frame handed to the block is compared against every enabled object in the same cycle. The lowest-numbered object whose identifier and remote flag both equal those of the frame wins.

A matching data frame has its payload and length stored in the winning object's buffer. The object's ready flag is set, and the interrupt output follows the ready flags of objects whose interrupt is enabled. A matching remote frame is answered automatically: it can only match an object whose remote flag is set, and it issues a reply request naming that object. A frame that matches nothing is dropped without side effects. The host reads stored payloads through a combinational read port and clears ready flags with a write-one-to-clear mask.

Frames enter on a valid/ready stream. A frame transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while a reply request is waiting. Reply requests leave on a second valid/ready stream. Once `rply_valid` is raised, it and `rply_obj` hold steady until a cycle in which `rply_ready` is high. The consumer may hold `rply_ready` low for as long as it likes, and this stalls the frame input.

Top module: `msg_accept_filter`

## Requirements
- R1: After reset, every object is disabled, all ready flags are 0, `irq` is 0, `rply_valid` is 0 and `in_ready` is 1.
- R2: A frame matches an object only when the object is enabled, its identifier equals `in_id`, and its remote flag equals `in_rtr`. All objects are compared at once, and the outcome takes effect at the edge where the frame is accepted.
- R3: An accepted data frame (`in_rtr`=0) that matches stores its payload and length in the winning object. Byte k is `in_data[8k+7:8k]`. Bytes at positions at or above the length read as zero, and a length above 8 is stored as 8. The object's ready flag is set. The new values are visible from the cycle after acceptance.
- R4: `irq` is high exactly while some object has both its ready flag and its interrupt enable set.
- R5: A frame that matches no object changes no buffer, no ready flag and no output.
- R6: When several objects match, only the lowest-numbered one is updated or answered.
- R7: An accepted remote frame (`in_rtr`=1) that matches raises `rply_valid` in the next cycle, with the winning object index on `rply_obj`, and changes no ready flag or buffer. A remote frame whose identifier is held only by objects with the remote flag clear gets no reply.
- R8: While `rply_valid` is high, `in_ready` is 0. `rply_valid` and `rply_obj` hold until a cycle with `rply_ready` high, and drop after that edge.
- R9: `clr_en` clears every ready flag whose bit is 1 in `clr_mask`. If a flag is set and cleared at the same edge, it ends up set.
- R10: A frame accepted in the same cycle as a host write to its winning object is discarded. The rewritten entry is used from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write one table entry |
| cfg_obj | input | 4 | Object index to write |
| cfg_id | input | 11 | Identifier for the entry |
| cfg_rtr | input | 1 | Remote flag for the entry |
| cfg_en | input | 1 | Entry enable |
| cfg_ie | input | 1 | Entry interrupt enable |
| clr_en | input | 1 | Apply the ready-flag clear mask |
| clr_mask | input | 16 | Write-one-to-clear mask for the ready flags |
| in_valid | input | 1 | Frame present |
| in_ready | output | 1 | Frame can be accepted |
| in_id | input | 11 | Frame identifier |
| in_rtr | input | 1 | Frame is a remote request |
| in_len | input | 4 | Frame payload length in bytes |
| in_data | input | 64 | Frame payload, byte k in bits 8k+7:8k |
| rply_valid | output | 1 | Automatic reply request pending |
| rply_ready | input | 1 | Consumer takes the reply request |
| rply_obj | output | 4 | Object to send as the reply |
| rdy_flags | output | 16 | Per-object ready flags |
| irq | output | 1 | Receive interrupt |
| rd_obj | input | 4 | Object selected for reading |
| rd_len | output | 4 | Stored length of the selected object |
| rd_data | output | 64 | Stored payload of the selected object |

## Verification
Two situations are hard to reach from the ports. One is a host write that lands on the very edge where a frame for the rewritten object is accepted. The other is a flag clear that coincides with a new set. The bench drives `cfg_we` or `clr_en` on the same falling edge as `in_valid`, so both reach one rising edge. It then reads the buffer and flags back through the ports. A stalled reply consumer is also held for several cycles while a frame waits, to show that the input stays blocked and the reply stays steady.

// File: rtl/maf_pkg.sv
package maf_pkg;
  localparam int ID_W = 11;

  typedef struct packed {
    logic            en;
    logic            rtr;
    logic            ie;
    logic [ID_W-1:0] id;
  } obj_entry_t;
endpackage

// File: rtl/maf_cam.sv
module maf_cam
  import maf_pkg::*;
#(
  parameter int N_OBJ = 16,
  localparam int IDX_W = $clog2(N_OBJ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_obj,
  input  obj_entry_t       cfg_entry,
  input  logic [ID_W-1:0]  q_id,
  input  logic             q_rtr,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic [N_OBJ-1:0] ie_vec
);
  obj_entry_t       table_q [N_OBJ];
  logic [N_OBJ-1:0] match;

  for (genvar g = 0; g < N_OBJ; g++) begin : g_obj
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) table_q[g] <= '0;
      else if (cfg_we && cfg_obj == IDX_W'(g)) table_q[g] <= cfg_entry;
    end
    assign match[g]  = table_q[g].en && (table_q[g].id == q_id) && (table_q[g].rtr == q_rtr);
    assign ie_vec[g] = table_q[g].ie;
  end

  // Lowest-numbered match wins
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = N_OBJ - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  a_r2_hit_is_match: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> match[hit_idx]);
  a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((match & ((N_OBJ'(1) << hit_idx) - N_OBJ'(1))) == '0));
endmodule

// File: rtl/maf_store.sv
module maf_store #(
  parameter int N_OBJ = 16,
  parameter int MAX_BYTES = 8,
  localparam int IDX_W = $clog2(N_OBJ),
  localparam int LEN_W = $clog2(MAX_BYTES + 1),
  localparam int DATA_W = 8 * MAX_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_obj,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_en,
  input  logic [N_OBJ-1:0]  clr_mask,
  input  logic [IDX_W-1:0]  rd_obj,
  output logic [LEN_W-1:0]  rd_len,
  output logic [DATA_W-1:0] rd_data,
  output logic [N_OBJ-1:0]  rdy
);
  logic [LEN_W-1:0]  len_q  [N_OBJ];
  logic [DATA_W-1:0] data_q [N_OBJ];
  logic [LEN_W-1:0]  len_eff;
  logic [DATA_W-1:0] data_msk;
  logic [N_OBJ-1:0]  set_vec, clr_vec;

  assign len_eff = (wr_len > LEN_W'(MAX_BYTES)) ? LEN_W'(MAX_BYTES) : wr_len;

  for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte
    assign data_msk[8*b +: 8] = (LEN_W'(b) < len_eff) ? wr_data[8*b +: 8] : 8'h00;
  end

  for (genvar g = 0; g < N_OBJ; g++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        len_q[g]  <= '0;
        data_q[g] <= '0;
      end else if (wr_en && wr_obj == IDX_W'(g)) begin
        len_q[g]  <= len_eff;
        data_q[g] <= data_msk;
      end
    end
  end

  assign set_vec = wr_en ? (N_OBJ'(1) << wr_obj) : '0;
  assign clr_vec = clr_en ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy <= '0;
    else        rdy <= (rdy & ~clr_vec) | set_vec;
  end

  assign rd_len  = len_q[rd_obj];
  assign rd_data = data_q[rd_obj];

  a_r3_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rdy[$past(wr_obj)]);
  a_r9_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !wr_en) |=> ((rdy & $past(clr_mask)) == '0));
  a_r5_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !clr_en) |=> $stable(rdy));
endmodule

// File: rtl/msg_accept_filter.sv
module msg_accept_filter
  import maf_pkg::*;
#(
  parameter int N_OBJ = 16,
  parameter int MAX_BYTES = 8,
  localparam int IDX_W = $clog2(N_OBJ),
  localparam int LEN_W = $clog2(MAX_BYTES + 1),
  localparam int DATA_W = 8 * MAX_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_obj,
  input  logic [ID_W-1:0]   cfg_id,
  input  logic              cfg_rtr,
  input  logic              cfg_en,
  input  logic              cfg_ie,
  input  logic              clr_en,
  input  logic [N_OBJ-1:0]  clr_mask,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ID_W-1:0]   in_id,
  input  logic              in_rtr,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [DATA_W-1:0] in_data,
  output logic              rply_valid,
  input  logic              rply_ready,
  output logic [IDX_W-1:0]  rply_obj,
  output logic [N_OBJ-1:0]  rdy_flags,
  output logic              irq,
  input  logic [IDX_W-1:0]  rd_obj,
  output logic [LEN_W-1:0]  rd_len,
  output logic [DATA_W-1:0] rd_data
);
  obj_entry_t       cfg_entry;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic [N_OBJ-1:0] ie_vec;
  logic             accept, collide, take, store_en;

  assign cfg_entry = '{en: cfg_en, rtr: cfg_rtr, ie: cfg_ie, id: cfg_id};

  maf_cam #(.N_OBJ(N_OBJ)) u_cam (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_obj(cfg_obj), .cfg_entry(cfg_entry),
    .q_id(in_id), .q_rtr(in_rtr),
    .hit(hit), .hit_idx(hit_idx), .ie_vec(ie_vec)
  );

  assign in_ready = !rply_valid;
  assign accept   = in_valid && in_ready;
  assign collide  = cfg_we && (cfg_obj == hit_idx);
  assign take     = accept && hit && !collide;
  assign store_en = take && !in_rtr;

  maf_store #(.N_OBJ(N_OBJ), .MAX_BYTES(MAX_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(store_en), .wr_obj(hit_idx), .wr_len(in_len), .wr_data(in_data),
    .clr_en(clr_en), .clr_mask(clr_mask),
    .rd_obj(rd_obj), .rd_len(rd_len), .rd_data(rd_data),
    .rdy(rdy_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rply_valid <= 1'b0;
      rply_obj   <= '0;
    end else if (take && in_rtr) begin
      rply_valid <= 1'b1;
      rply_obj   <= hit_idx;
    end else if (rply_valid && rply_ready) begin
      rply_valid <= 1'b0;
    end
  end

  assign irq = |(rdy_flags & ie_vec);

  a_r8_reply_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rply_valid && !rply_ready) |=> (rply_valid && $stable(rply_obj)));
  a_r7_remote_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_rtr && !clr_en) |=> $stable(rdy_flags));
  a_r10_collide_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && collide && !in_rtr && !clr_en) |=> $stable(rdy_flags));
endmodule

// File: tb/msg_accept_filter_tb.sv
`timescale 1ns/1ps
module msg_accept_filter_tb;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0, cfg_rtr = 0, cfg_en = 0, cfg_ie = 0;
  logic [3:0]  cfg_obj = 0;
  logic [10:0] cfg_id = 0;
  logic        clr_en = 0;
  logic [15:0] clr_mask = 0;
  logic        in_valid = 0, in_rtr = 0;
  logic        in_ready;
  logic [10:0] in_id = 0;
  logic [3:0]  in_len = 0;
  logic [63:0] in_data = 0;
  logic        rply_valid, rply_ready = 1;
  logic [3:0]  rply_obj;
  logic [15:0] rdy_flags;
  logic        irq;
  logic [3:0]  rd_obj = 0, rd_len;
  logic [63:0] rd_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int exp_q[$];

  msg_accept_filter u_dut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] masked(logic [63:0] d, int len);
    logic [63:0] r = '0;
    int eff = (len > 8) ? 8 : len;
    for (int b = 0; b < eff; b++) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  // All tasks start and end right after a falling edge
  task automatic cfg_write(int obj, int id, bit rtr, bit en, bit ie);
    cfg_we = 1; cfg_obj = 4'(obj); cfg_id = 11'(id);
    cfg_rtr = rtr; cfg_en = en; cfg_ie = ie;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic clear(logic [15:0] m);
    clr_en = 1; clr_mask = m;
    @(negedge clk);
    clr_en = 0;
  endtask

  // Extras (cfg_we, clr_en) preset by the caller share the acceptance edge
  task automatic send_frame(int id, bit rtr, int len, logic [63:0] d);
    in_id = 11'(id); in_rtr = rtr; in_len = 4'(len); in_data = d;
    in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0; cfg_we = 0; clr_en = 0;
  endtask

  task automatic read_obj(int obj, string req, int exp_len, logic [63:0] exp_d);
    rd_obj = 4'(obj);
    #0.5;
    chk({req, " len"}, 64'(rd_len), 64'(exp_len));
    chk({req, " data"}, rd_data, exp_d);
  endtask

  // Scoreboard monitor for reply requests (R7, R8)
  always @(negedge clk) begin
    #1;
    if (rst_n && rply_valid && rply_ready) begin
      int e;
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R7 unexpected reply actual=%0d expected=none", rply_obj);
      end else begin
        e = exp_q.pop_front();
        if (rply_obj != 4'(e)) begin
          n_fail++;
          $display("FAIL R7 reply object actual=%0d expected=%0d", rply_obj, e);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] d9, d3, d9b;
    d9  = 64'h8877_6655_4433_2211;
    d3  = 64'hA1B2_C3D4_E5F6_0718;
    d9b = 64'h0F0E_0D0C_0B0A_0908;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 flags", 64'(rdy_flags), 0);
    chk("R1 irq", 64'(irq), 0);
    chk("R1 rply_valid", 64'(rply_valid), 0);
    chk("R1 in_ready", 64'(in_ready), 1);

    cfg_write(3, 'h123, 0, 1, 1);
    cfg_write(5, 'h123, 0, 1, 0);
    cfg_write(7, 'h2A5, 1, 1, 0);
    cfg_write(9, 'h055, 0, 1, 0);
    cfg_write(10, 'h666, 0, 0, 1);

    // R3 full frame into object 9, interrupt disabled (R4)
    send_frame('h055, 0, 8, d9);
    chk("R3 flag9", 64'(rdy_flags), 64'h0200);
    chk("R4 irq off when ie clear", 64'(irq), 0);
    read_obj(9, "R3 obj9", 8, d9);

    // R6 two matches, lowest wins; R3 short length masking
    send_frame('h123, 0, 3, d3);
    chk("R6 lowest only", 64'(rdy_flags), 64'h0208);
    chk("R4 irq on", 64'(irq), 1);
    read_obj(3, "R3 obj3", 3, masked(d3, 3));
    read_obj(5, "R6 obj5 untouched", 0, 0);

    // R2 disabled entry, R5 unknown identifier
    send_frame('h666, 0, 2, 64'hFFFF);
    chk("R2 disabled entry", 64'(rdy_flags), 64'h0208);
    read_obj(10, "R2 obj10", 0, 0);
    send_frame('h124, 0, 8, 64'h1);
    chk("R5 no match", 64'(rdy_flags), 64'h0208);
    chk("R5 no reply", 64'(rply_valid), 0);

    // R7 remote frame against receive-only entries: no reply
    send_frame('h123, 1, 0, 0);
    chk("R7 no reply for rtr-clear entry", 64'(rply_valid), 0);
    read_obj(3, "R7 obj3 kept", 3, masked(d3, 3));
    // R2 data frame against an rtr-set entry: no match
    send_frame('h2A5, 0, 4, 64'hDEAD);
    chk("R2 rtr mismatch", 64'(rdy_flags), 64'h0208);

    // R7 remote frame served
    exp_q.push_back(7);
    send_frame('h2A5, 1, 0, 0);
    chk("R7 flags unchanged", 64'(rdy_flags), 64'h0208);
    @(negedge clk);
    chk("R7 reply consumed", 64'(rply_valid), 0);

    // R8 back-pressure
    rply_ready = 0;
    exp_q.push_back(7);
    send_frame('h2A5, 1, 0, 0);
    in_id = 'h055; in_rtr = 0; in_len = 2; in_data = 64'h5555; in_valid = 1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R8 in_ready low", 64'(in_ready), 0);
      chk("R8 reply held", 64'({rply_valid, rply_obj}), 64'({1'b1, 4'd7}));
      @(negedge clk);
    end
    chk("R8 frame not taken", 64'(rdy_flags), 64'h0208);
    in_valid = 0; rply_ready = 1;
    @(negedge clk);
    chk("R8 reply drops", 64'(rply_valid), 0);
    chk("R8 in_ready back", 64'(in_ready), 1);
    read_obj(9, "R8 obj9 kept", 8, d9);

    // R9 clear
    clear(16'h0008);
    chk("R9 cleared", 64'(rdy_flags), 64'h0200);
    chk("R4 irq follows clear", 64'(irq), 0);
    clear(16'h0200);
    chk("R9 cleared 9", 64'(rdy_flags), 0);
    clr_en = 1; clr_mask = 16'h0200;
    send_frame('h055, 0, 12, d9b);
    chk("R9 set wins", 64'(rdy_flags), 64'h0200);
    read_obj(9, "R3 long length clamped", 8, d9b);
    clear(16'h0200);

    // R10 rewrite colliding with a frame for the same object
    cfg_we = 1; cfg_obj = 9; cfg_id = 'h077; cfg_rtr = 0; cfg_en = 1; cfg_ie = 1;
    send_frame('h055, 0, 1, 64'hAA);
    chk("R10 frame dropped", 64'(rdy_flags), 0);
    read_obj(9, "R10 buffer kept", 8, d9b);
    send_frame('h077, 0, 1, 64'hBB);
    chk("R10 new id used", 64'(rdy_flags), 64'h0200);
    chk("R4 irq new ie", 64'(irq), 1);
    read_obj(9, "R10 new data", 1, 64'hBB);

    repeat (2) @(negedge clk);
    chk("R7 scoreboard drained", 64'(exp_q.size()), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule